// File: doc/BRIEF.md
# Input-Monitor Bring-Up and Fault Poll Sequencer

This block drives a register-access master that talks serially to an eight-channel digital input monitor. After reset it brings the monitor up with a fixed sequence of register writes. It then clears the monitor's power-on flag with a read followed by a write. Once that is done it waits for poll requests. On each poll it looks at an active-high fault line. If the line is set, it reads the two levels of fault registers, but only the ones whose summary bits call for it. Every poll then ends with a read of the wire-break register. Each response carries the live input states in its first byte, so the input vector is refreshed on every response.

The master interface carries one transaction at a time. The block raises a request carrying a 7-bit register address, a write flag and a data byte. It holds that request until `req_ready` accepts it, then waits for a single response. The response returns two bytes and a CRC-error flag. The per-channel filter settings and the four fault configuration bytes come in as static configuration inputs. The block presents the last value read from each fault register, the wire-break vector, the input vector, a busy flag and a sticky CRC-error flag.

The controller has a state register and a separate waiting bit. The waiting bit is low while the request is offered and high while the response is awaited.
- **Initialisation states**, taken in this order: `S_I_SUM_EN` → `S_I_SUM` → `S_I_DET_EN` → `S_I_DET` → `S_I_FILT` (repeated once per channel) → `S_I_PORRD` → `S_I_PORWR` → `S_IDLE`.
- **Leaving `S_IDLE`:** a poll moves to `S_P_SUM` if the fault line is set, otherwise to `S_P_WB`.
- **Leaving `S_P_SUM`:** to `S_P_SUM_EN` if the value read is nonzero, otherwise to `S_P_WB`.
- **Leaving `S_P_SUM_EN`:** to `S_P_WBF` if the wire-break bit is set in both values, otherwise to `S_P_DET` if summary bit 5 is set, otherwise to `S_P_WB`.
- **Leaving `S_P_WBF`:** to `S_P_DET` if summary bit 5 is set, otherwise to `S_P_WB`.
- **Rest of the poll:** `S_P_DET` → `S_P_DET_EN` → `S_P_WB` → `S_IDLE`.
- **CRC error:** a response that flags one sends any state straight to `S_IDLE`.

Top module: `fault_poll_seq`

## Requirements
- R1: After reset the block issues exactly fourteen transactions, in this order:
  - writes to 0x24, 0x04, 0x1E and 0x1C, carrying `cfg_sum_en` (with bits forced as in R2), `cfg_sum`, `cfg_det_en` and `cfg_det`;
  - eight filter writes to 0x06 + 2·n for n = 0..7;
  - a read of 0x04;
  - a write to 0x04 of the value just read with bit 6 cleared.
- R2: The byte written to 0x24 during initialisation is `cfg_sum_en` with bit 0 and bit 6 forced to 1.
- R3: Each filter byte has the channel's delay code in bits 2:0, `cfg_bypass[n]` in bit 3, `cfg_wb_en[n]` in bit 4, and zeros in bits 7:5.
- R4: The delay code is chosen from the channel's delay in microseconds, with any other value mapping to code 7:

  | Delay (µs) | 50 | 100 | 400 | 800 | 1600 | 3200 | 12800 | 20000 |
  |---|---|---|---|---|---|---|---|---|
  | Code | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 |

- R5: A poll taken while `fault_in` is low issues a single read of 0x00. That read request appears in the cycle after the poll is sampled.
- R6: A poll taken while `fault_in` is high first reads 0x04 into `flt_sum`. Only if that value is nonzero does it next read 0x24 into `flt_sum_en`.
- R7: If bit 0 of both `flt_sum` and `flt_sum_en` is set, the block reads 0x00 right after 0x24 and loads byte 1 of the response into `wb_vec`.
- R8: If bit 5 of `flt_sum` is set, the block reads 0x1C into `flt_det` and then 0x1E into `flt_det_en`.
- R9: Every poll ends with a read of 0x00, whose byte 1 loads `wb_vec`. Every error-free response loads byte 0 into `in_vec`, and every error-free write response loads byte 1 into `wb_vec`.
- R10: A response with `rsp_crc_err` set updates none of the outputs and ends the sequence at once: `busy` falls after that edge and no further request follows. It also sets `crc_error`, which stays high until reset.
- R11: `busy` is high from reset, and from the edge on which a poll is taken, until the edge that takes the last response of the sequence. `poll_req` has no effect while `busy` is high.
- R12: A request holds its address, write flag and data unchanged until it is accepted, and only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; each release starts initialisation |
| poll_req | input | 1 | Poll request, sampled while idle |
| fault_in | input | 1 | Active-high fault line from the monitor |
| cfg_sum_en | input | 8 | Fault-enable byte written to 0x24 |
| cfg_sum | input | 8 | Byte written to 0x04 at initialisation |
| cfg_det_en | input | 8 | Byte written to 0x1E |
| cfg_det | input | 8 | Byte written to 0x1C |
| cfg_dly_us | input | 128 | Per-channel filter delay in microseconds, 16 bits per channel |
| cfg_bypass | input | 8 | Per-channel filter bypass |
| cfg_wb_en | input | 8 | Per-channel wire-break detection enable |
| req_valid | output | 1 | Request offered to the master |
| req_ready | input | 1 | Master accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 7 | Register address |
| req_data | output | 8 | Write data (zero for reads) |
| rsp_valid | input | 1 | Response present |
| rsp_crc_err | input | 1 | Response failed its CRC check |
| rsp_byte0 | input | 8 | Response byte 0: input states |
| rsp_byte1 | input | 8 | Response byte 1: read data, or wire-break byte on writes |
| flt_sum | output | 8 | Last value read from 0x04 |
| flt_sum_en | output | 8 | Last value read from 0x24 |
| flt_det | output | 8 | Last value read from 0x1C |
| flt_det_en | output | 8 | Last value read from 0x1E |
| wb_vec | output | 8 | Wire-break vector |
| in_vec | output | 8 | Input state vector |
| busy | output | 1 | A sequence is in progress |
| crc_error | output | 1 | Sticky CRC-error flag |

## Verification
A request appears in the cycle after the edge that starts its step, or that took the previous response. `busy` rises on the edge that samples the poll. Every output register loads on the edge that takes an error-free response and is readable from the next cycle. `busy` and `crc_error` change on the edge that takes the last or the flagged response.

The bench drives and samples only on falling edges. It judges a sequence only after `busy` has been seen low and then lets four more cycles pass, so every register on the path has settled. The number of idle cycles before each response is random, so the state machine never relies on a fixed response delay.

// File: rtl/fps_pkg.sv
package fps_pkg;

    parameter int unsigned ADDR_W = 7;
    parameter int unsigned DATA_W = 8;

    // register addresses decoded by the monitor
    localparam logic [ADDR_W-1:0] A_INWB   = 7'h00;
    localparam logic [ADDR_W-1:0] A_SUM    = 7'h04;
    localparam logic [ADDR_W-1:0] A_FILT0  = 7'h06;
    localparam logic [ADDR_W-1:0] A_DET    = 7'h1C;
    localparam logic [ADDR_W-1:0] A_DET_EN = 7'h1E;
    localparam logic [ADDR_W-1:0] A_SUM_EN = 7'h24;

    // bit positions inside the summary and summary-enable bytes
    localparam int unsigned SUM_WB_BIT  = 0;
    localparam int unsigned SUM_DET_BIT = 5;
    localparam int unsigned SUM_POR_BIT = 6;

    localparam logic [DATA_W-1:0] SUM_EN_FORCE =
        DATA_W'((1 << SUM_WB_BIT) | (1 << SUM_POR_BIT));
    localparam logic [DATA_W-1:0] POR_CLR_MASK = ~DATA_W'(1 << SUM_POR_BIT);

    typedef enum logic [3:0] {
        S_IDLE,
        S_I_SUM_EN,
        S_I_SUM,
        S_I_DET_EN,
        S_I_DET,
        S_I_FILT,
        S_I_PORRD,
        S_I_PORWR,
        S_P_SUM,
        S_P_SUM_EN,
        S_P_WBF,
        S_P_DET,
        S_P_DET_EN,
        S_P_WB
    } fps_state_e;

    function automatic logic [2:0] dly_code(input int unsigned us);
        logic [2:0] c;
        case (us)
            50:      c = 3'd0;
            100:     c = 3'd1;
            400:     c = 3'd2;
            800:     c = 3'd3;
            1600:    c = 3'd4;
            3200:    c = 3'd5;
            12800:   c = 3'd6;
            20000:   c = 3'd7;
            default: c = 3'd7;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fps_filter_enc.sv
module fps_filter_enc #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned DLY_W = 16
) (
    input  logic [NCH*DLY_W-1:0]          dly_us,
    input  logic [NCH-1:0]                bypass,
    input  logic [NCH-1:0]                wb_en,
    output logic [NCH*fps_pkg::DATA_W-1:0] filt_bytes
);
    localparam int unsigned DW  = fps_pkg::DATA_W;
    localparam int unsigned PAD = DW - 5;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic [2:0] code;
            assign code = fps_pkg::dly_code(32'(dly_us[g*DLY_W +: DLY_W]));
            assign filt_bytes[g*DW +: DW] = {{PAD{1'b0}}, wb_en[g], bypass[g], code};
        end
    endgenerate

endmodule

// File: rtl/fps_req_build.sv
module fps_req_build #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned IDX_W = 3
) (
    input  fps_pkg::fps_state_e                state,
    input  logic [IDX_W-1:0]                   filt_idx,
    input  logic [NCH*fps_pkg::DATA_W-1:0]     filt_bytes,
    input  logic [fps_pkg::DATA_W-1:0]         cfg_sum_en,
    input  logic [fps_pkg::DATA_W-1:0]         cfg_sum,
    input  logic [fps_pkg::DATA_W-1:0]         cfg_det_en,
    input  logic [fps_pkg::DATA_W-1:0]         cfg_det,
    input  logic [fps_pkg::DATA_W-1:0]         por_val,
    output logic [fps_pkg::ADDR_W-1:0]         addr,
    output logic                               wr,
    output logic [fps_pkg::DATA_W-1:0]         data
);
    import fps_pkg::*;

    always_comb begin
        addr = A_INWB;
        wr   = 1'b0;
        data = '0;
        case (state)
            S_I_SUM_EN: begin addr = A_SUM_EN; wr = 1'b1; data = cfg_sum_en | SUM_EN_FORCE; end
            S_I_SUM:    begin addr = A_SUM;    wr = 1'b1; data = cfg_sum;    end
            S_I_DET_EN: begin addr = A_DET_EN; wr = 1'b1; data = cfg_det_en; end
            S_I_DET:    begin addr = A_DET;    wr = 1'b1; data = cfg_det;    end
            S_I_FILT: begin
                addr = A_FILT0 + ADDR_W'({filt_idx, 1'b0});
                wr   = 1'b1;
                data = filt_bytes[filt_idx*DATA_W +: DATA_W];
            end
            S_I_PORRD:  begin addr = A_SUM; end
            S_I_PORWR:  begin addr = A_SUM; wr = 1'b1; data = por_val & POR_CLR_MASK; end
            S_P_SUM:    addr = A_SUM;
            S_P_SUM_EN: addr = A_SUM_EN;
            S_P_WBF:    addr = A_INWB;
            S_P_DET:    addr = A_DET;
            S_P_DET_EN: addr = A_DET_EN;
            S_P_WB:     addr = A_INWB;
            default:    addr = A_INWB;
        endcase
    end

endmodule

// File: rtl/fault_poll_seq.sv
module fault_poll_seq #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned DLY_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       poll_req,
    input  logic                       fault_in,
    input  logic [7:0]                 cfg_sum_en,
    input  logic [7:0]                 cfg_sum,
    input  logic [7:0]                 cfg_det_en,
    input  logic [7:0]                 cfg_det,
    input  logic [NCH*DLY_W-1:0]       cfg_dly_us,
    input  logic [NCH-1:0]             cfg_bypass,
    input  logic [NCH-1:0]             cfg_wb_en,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic                       req_write,
    output logic [6:0]                 req_addr,
    output logic [7:0]                 req_data,
    input  logic                       rsp_valid,
    input  logic                       rsp_crc_err,
    input  logic [7:0]                 rsp_byte0,
    input  logic [7:0]                 rsp_byte1,
    output logic [7:0]                 flt_sum,
    output logic [7:0]                 flt_sum_en,
    output logic [7:0]                 flt_det,
    output logic [7:0]                 flt_det_en,
    output logic [NCH-1:0]             wb_vec,
    output logic [NCH-1:0]             in_vec,
    output logic                       busy,
    output logic                       crc_error
);
    import fps_pkg::*;

    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    fps_state_e        state, nstate, succ;
    logic              waiting, nwait;
    logic [IDX_W-1:0]  filt_idx, nidx;
    logic [7:0]        por_val;
    logic [NCH*8-1:0]  filt_bytes;
    logic              rsp_take, rsp_good;

    fps_filter_enc #(.NCH(NCH), .DLY_W(DLY_W)) u_enc (
        .dly_us     (cfg_dly_us),
        .bypass     (cfg_bypass),
        .wb_en      (cfg_wb_en),
        .filt_bytes (filt_bytes)
    );

    fps_req_build #(.NCH(NCH), .IDX_W(IDX_W)) u_req (
        .state      (state),
        .filt_idx   (filt_idx),
        .filt_bytes (filt_bytes),
        .cfg_sum_en (cfg_sum_en),
        .cfg_sum    (cfg_sum),
        .cfg_det_en (cfg_det_en),
        .cfg_det    (cfg_det),
        .por_val    (por_val),
        .addr       (req_addr),
        .wr         (req_write),
        .data       (req_data)
    );

    assign busy      = (state != S_IDLE);
    assign req_valid = busy && !waiting;
    assign rsp_take  = waiting && rsp_valid;
    assign rsp_good  = rsp_take && !rsp_crc_err;

    // successor of the current step once its response is good
    always_comb begin
        succ = S_IDLE;
        case (state)
            S_I_SUM_EN: succ = S_I_SUM;
            S_I_SUM:    succ = S_I_DET_EN;
            S_I_DET_EN: succ = S_I_DET;
            S_I_DET:    succ = S_I_FILT;
            S_I_FILT:   succ = (filt_idx == LAST_IDX) ? S_I_PORRD : S_I_FILT;
            S_I_PORRD:  succ = S_I_PORWR;
            S_I_PORWR:  succ = S_IDLE;
            S_P_SUM:    succ = (rsp_byte1 != 8'h00) ? S_P_SUM_EN : S_P_WB;
            S_P_SUM_EN: begin
                if (flt_sum[SUM_WB_BIT] && rsp_byte1[SUM_WB_BIT])
                    succ = S_P_WBF;
                else if (flt_sum[SUM_DET_BIT])
                    succ = S_P_DET;
                else
                    succ = S_P_WB;
            end
            S_P_WBF:    succ = flt_sum[SUM_DET_BIT] ? S_P_DET : S_P_WB;
            S_P_DET:    succ = S_P_DET_EN;
            S_P_DET_EN: succ = S_P_WB;
            S_P_WB:     succ = S_IDLE;
            default:    succ = S_IDLE;
        endcase
    end

    always_comb begin
        nstate = state;
        nwait  = waiting;
        nidx   = filt_idx;
        if (state == S_IDLE) begin
            if (poll_req)
                nstate = fault_in ? S_P_SUM : S_P_WB;
        end else if (!waiting) begin
            if (req_ready)
                nwait = 1'b1;
        end else if (rsp_valid) begin
            nwait = 1'b0;
            if (rsp_crc_err) begin
                nstate = S_IDLE;
                nidx   = '0;
            end else begin
                nstate = succ;
                if (state == S_I_FILT)
                    nidx = (succ == S_I_FILT) ? filt_idx + 1'b1 : '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_I_SUM_EN;
            waiting  <= 1'b0;
            filt_idx <= '0;
        end else begin
            state    <= nstate;
            waiting  <= nwait;
            filt_idx <= nidx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_sum    <= '0;
            flt_sum_en <= '0;
            flt_det    <= '0;
            flt_det_en <= '0;
            wb_vec     <= '0;
            in_vec     <= '0;
            por_val    <= '0;
            crc_error  <= 1'b0;
        end else begin
            if (rsp_take && rsp_crc_err)
                crc_error <= 1'b1;
            if (rsp_good) begin
                in_vec <= rsp_byte0[NCH-1:0];
                if (req_write)
                    wb_vec <= rsp_byte1[NCH-1:0];
                case (state)
                    S_I_PORRD:  por_val    <= rsp_byte1;
                    S_P_SUM:    flt_sum    <= rsp_byte1;
                    S_P_SUM_EN: flt_sum_en <= rsp_byte1;
                    S_P_WBF:    wb_vec     <= rsp_byte1[NCH-1:0];
                    S_P_DET:    flt_det    <= rsp_byte1;
                    S_P_DET_EN: flt_det_en <= rsp_byte1;
                    S_P_WB:     wb_vec     <= rsp_byte1[NCH-1:0];
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
    parameter int unsigned NCH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_req,
    input logic       fault_in,
    input logic       busy,
    input logic       waiting,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [6:0] req_addr,
    input logic [7:0] req_data,
    input logic       rsp_valid,
    input logic       rsp_crc_err,
    input logic       crc_error
);
    localparam logic [6:0] FILT_LO = 7'h06;
    localparam logic [6:0] FILT_HI = 7'(7'h06 + 2 * NCH);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_data)));

    // R2
    sum_en_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 7'h24) |-> (req_data[0] && req_data[6]));

    // R3
    filt_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr >= FILT_LO && req_addr < FILT_HI)
            |-> (req_data[7:5] == 3'b000));

    // R10
    crc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rsp_valid && rsp_crc_err) |=> (!busy && crc_error));

    // R10
    crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> crc_error);

    // R5
    quiet_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && poll_req && !fault_in) |=> (req_valid && !req_write && req_addr == 7'h00));

    // R6
    fault_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && poll_req && fault_in) |=> (req_valid && !req_write && req_addr == 7'h04));

endmodule

bind fault_poll_seq fps_chk #(.NCH(NCH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_req    (poll_req),
    .fault_in    (fault_in),
    .busy        (busy),
    .waiting     (waiting),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .rsp_valid   (rsp_valid),
    .rsp_crc_err (rsp_crc_err),
    .crc_error   (crc_error)
);

// File: tb/test_fault_poll_seq.sv
module test_fault_poll_seq;
    localparam int NCH   = 8;
    localparam int DLY_W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, poll_req, fault_in;
    logic [7:0] cfg_sum_en, cfg_sum, cfg_det_en, cfg_det;
    logic [NCH*DLY_W-1:0] cfg_dly_us;
    logic [NCH-1:0] cfg_bypass, cfg_wb_en;
    logic req_valid, req_ready, req_write;
    logic [6:0] req_addr;
    logic [7:0] req_data;
    logic rsp_valid, rsp_crc_err;
    logic [7:0] rsp_byte0, rsp_byte1;
    logic [7:0] flt_sum, flt_sum_en, flt_det, flt_det_en;
    logic [NCH-1:0] wb_vec, in_vec;
    logic busy, crc_error;

    fault_poll_seq #(.NCH(NCH), .DLY_W(DLY_W)) i_fault_poll_seq (.*);

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] dev_regs [0:127];
    logic [7:0] dev_in;
    logic [6:0] log_addr [0:63];
    logic       log_wr   [0:63];
    logic [7:0] log_data [0:63];
    int log_n = 0;
    int crc_at = -1;

    logic [6:0] exp_a [0:15];
    int exp_n;
    logic [7:0] e_sum, e_sum_en, e_det, e_det_en, e_wb;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [2:0] code_of(input int us);
        case (us)
            50: return 3'd0;
            100: return 3'd1;
            400: return 3'd2;
            800: return 3'd3;
            1600: return 3'd4;
            3200: return 3'd5;
            12800: return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    function automatic int pick_delay(input int sel);
        case (sel)
            0: return 50;     1: return 100;   2: return 400;  3: return 800;
            4: return 1600;   5: return 3200;  6: return 12800; 7: return 20000;
            8: return 1800;   9: return 0;     10: return 7;   default: return 65535;
        endcase
    endfunction

    // monitor model answering the register master
    initial begin
        int k;
        logic [6:0] a;
        logic w;
        logic [7:0] d;
        req_ready = 0; rsp_valid = 0; rsp_crc_err = 0; rsp_byte0 = 0; rsp_byte1 = 0;
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                k = log_n; a = req_addr; w = req_write; d = req_data;
                if (k < 64) begin
                    log_addr[k] = a; log_wr[k] = w; log_data[k] = d;
                end
                log_n++;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                req_ready = 1;
                @(negedge clk);
                req_ready = 0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                if (w) begin
                    dev_regs[a] = d;
                    rsp_byte1 = dev_regs[0];
                end else begin
                    rsp_byte1 = dev_regs[a];
                end
                rsp_byte0 = dev_in;
                rsp_crc_err = (k == crc_at);
                rsp_valid = 1;
                @(negedge clk);
                rsp_valid = 0;
                rsp_crc_err = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input logic [6:0] a);
        exp_a[exp_n] = a;
        exp_n++;
    endtask

    task automatic do_poll(input bit f, input bit extra, input string tag);
        bit ok;
        exp_n = 0;
        if (f) begin
            push(7'h04);
            e_sum = dev_regs[7'h04];
            if (e_sum != 0) begin
                push(7'h24);
                e_sum_en = dev_regs[7'h24];
                if (e_sum[0] && e_sum_en[0]) push(7'h00);
                if (e_sum[5]) begin
                    push(7'h1C); push(7'h1E);
                    e_det = dev_regs[7'h1C];
                    e_det_en = dev_regs[7'h1E];
                end
            end
        end
        push(7'h00);
        e_wb = dev_regs[0];
        log_n = 0;
        @(negedge clk); poll_req = 1; fault_in = f;
        @(negedge clk); poll_req = 0;
        if (extra) begin
            @(negedge clk); poll_req = 1; fault_in = ~f;
            @(negedge clk); poll_req = 0;
        end
        wait_idle();
        // R11 a second pulse while busy adds nothing
        chk(log_n == exp_n, {tag, " R11 transaction count"}, log_n, exp_n);
        ok = 1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_addr[i] != exp_a[i] || log_wr[i]) ok = 0;
        // R5 R6 R7 R8 order of reads
        chk(ok, {tag, " R6 R7 R8 read order"}, log_addr[0], exp_a[0]);
        chk(in_vec == dev_in, {tag, " R9 in_vec"}, in_vec, dev_in);
        chk(wb_vec == e_wb, {tag, " R9 wb_vec"}, wb_vec, e_wb);
        chk(flt_sum == e_sum && flt_sum_en == e_sum_en, {tag, " R6 summary regs"},
            {flt_sum, flt_sum_en}, {e_sum, e_sum_en});
        chk(flt_det == e_det && flt_det_en == e_det_en, {tag, " R8 detail regs"},
            {flt_det, flt_det_en}, {e_det, e_det_en});
    endtask

    initial begin
        logic [7:0] exp_filt [0:NCH-1];
        bit ok;
        void'($urandom(32'd2718));
        rst_n = 0; poll_req = 0; fault_in = 0;
        cfg_sum_en = 8'($urandom); cfg_sum = 8'($urandom);
        cfg_det_en = 8'($urandom); cfg_det = 8'($urandom);
        cfg_bypass = NCH'($urandom); cfg_wb_en = NCH'($urandom);
        for (int n = 0; n < NCH; n++) begin
            int us;
            us = pick_delay((n < 8) ? n + 4 : $urandom_range(0, 11));
            if (n >= 4) us = pick_delay(n - 4);
            cfg_dly_us[n*DLY_W +: DLY_W] = DLY_W'(us);
            exp_filt[n] = {3'b000, cfg_wb_en[n], cfg_bypass[n], code_of(us)};
        end
        for (int i = 0; i < 128; i++) dev_regs[i] = 8'h00;
        dev_regs[0] = 8'($urandom);
        dev_in = 8'($urandom);
        e_sum = 0; e_sum_en = 0; e_det = 0; e_det_en = 0;

        repeat (3) @(negedge clk);
        chk(in_vec == 0 && wb_vec == 0 && flt_sum == 0 && !crc_error, "reset R9 R10 outputs clear",
            {in_vec, wb_vec, flt_sum}, 0);
        chk(busy == 1'b1, "reset R11 busy", busy, 1);

        log_n = 0;
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        poll_req = 1; fault_in = 1;          // R11 ignored during init
        @(negedge clk);
        poll_req = 0; fault_in = 0;
        wait_idle();
        repeat (6) @(negedge clk);
        chk(log_n == 14, "init R1 R11 transaction count", log_n, 14);
        exp_a[0] = 7'h24; exp_a[1] = 7'h04; exp_a[2] = 7'h1E; exp_a[3] = 7'h1C;
        for (int n = 0; n < NCH; n++) exp_a[4+n] = 7'(6 + 2*n);
        exp_a[12] = 7'h04; exp_a[13] = 7'h04;
        ok = 1;
        for (int i = 0; i < 14; i++) begin
            if (log_addr[i] != exp_a[i]) ok = 0;
            if (log_wr[i] != (i != 12)) ok = 0;
        end
        chk(ok, "init R1 address order", log_addr[0], exp_a[0]);
        chk(log_data[0] == (cfg_sum_en | 8'h41), "init R2 forced enables", log_data[0], cfg_sum_en | 8'h41);
        chk(log_data[1] == cfg_sum && log_data[2] == cfg_det_en && log_data[3] == cfg_det,
            "init R1 fault bytes", {log_data[1], log_data[2], log_data[3]}, {cfg_sum, cfg_det_en, cfg_det});
        for (int n = 0; n < NCH; n++)
            chk(log_data[4+n] == exp_filt[n], $sformatf("init R3 R4 filter byte %0d", n),
                log_data[4+n], exp_filt[n]);
        chk(log_data[13] == (cfg_sum & 8'hBF), "init R1 power-on flag cleared",
            log_data[13], cfg_sum & 8'hBF);
        chk(in_vec == dev_in && wb_vec == dev_regs[0], "init R9 vectors from responses",
            {in_vec, wb_vec}, {dev_in, dev_regs[0]});
        chk(!busy && flt_sum == 0, "init R11 idle afterwards", {busy, flt_sum}, 0);

        // directed polls
        dev_regs[0] = 8'h5A; dev_in = 8'hC3;
        do_poll(0, 0, "quiet R5");
        dev_regs[4] = 8'h00;
        do_poll(1, 0, "zero summary R6");
        dev_regs[4] = 8'h01; dev_regs[7'h24] = 8'h01; dev_regs[0] = 8'hA5;
        do_poll(1, 0, "wire-break R7");
        dev_regs[4] = 8'h01; dev_regs[7'h24] = 8'h40;
        do_poll(1, 0, "wb not enabled R7");
        dev_regs[4] = 8'h20; dev_regs[7'h1C] = 8'h3C; dev_regs[7'h1E] = 8'h11;
        do_poll(1, 0, "second level R8");
        do_poll(1, 1, "pulse while busy R11");

        for (int r = 0; r < 60; r++) begin
            dev_regs[4] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            dev_regs[7'h24] = 8'($urandom); dev_regs[7'h1C] = 8'($urandom);
            dev_regs[7'h1E] = 8'($urandom); dev_regs[0] = 8'($urandom);
            dev_in = 8'($urandom);
            do_poll(1'($urandom), ($urandom_range(0, 4) == 0), $sformatf("random %0d R9", r));
        end

        // R10 CRC error on the third transaction
        chk(!crc_error, "R10 flag clear before error", crc_error, 0);
        dev_regs[4] = 8'h21; dev_regs[7'h24] = 8'h01;
        dev_regs[0] = ~e_wb;
        crc_at = 2; log_n = 0;
        @(negedge clk); poll_req = 1; fault_in = 1;
        @(negedge clk); poll_req = 0;
        wait_idle();
        repeat (10) @(negedge clk);
        crc_at = -1;
        chk(log_n == 3, "R10 sequence aborted", log_n, 3);
        chk(crc_error && !busy, "R10 flag set and idle", {crc_error, busy}, 2'b10);
        chk(flt_sum == 8'h21 && flt_sum_en == 8'h01, "R10 earlier reads kept",
            {flt_sum, flt_sum_en}, 16'h2101);
        chk(wb_vec == e_wb, "R10 failed response ignored", wb_vec, e_wb);
        e_sum = 8'h21; e_sum_en = 8'h01;
        do_poll(0, 0, "after error R10");
        chk(crc_error, "R10 flag sticky", crc_error, 1);

        finish_up();
    end

endmodule